// File: doc/BRIEF.md
# Multi-Thread Gate Control Sequencer

This block plays back a time-aware egress schedule. One shared table of timeslots holds, for every slot, a hold duration counted in delta units, a mask of the egress ports the slot applies to, and a mask of the traffic classes whose transmission gates are closed while the slot is active. Up to eight execution threads walk this table at the same time. Each thread owns one contiguous range of slots, given by a first-slot address and a last-slot (end) index. Each thread also has its own start delay, counted from a common operational start time.

Software fills the slot table and the per-thread entries through the configuration write ports, sets the number of active threads and the start time, and then pulses `start`. A thread waits until the free-running time input reaches the start time plus its own delay. It then holds each slot for that slot's number of delta ticks, steps to the next slot, and returns to its first slot after its last one. Per port and per traffic class, the closed-gate outputs are the OR over all running threads whose current slot names that port. A `stop` pulse halts every thread, and all gates are open again one cycle later.

Top module: `gcl_sequencer`

## Requirements
- R1: After reset, `running` is 0 and every bit of `gate_closed` is 0 (all gates open).
- R2: A `start` pulse sets `running`. Each enabled thread then waits until `now >= base_time + delay` (unsigned, computed at the start pulse) and contributes nothing to `gate_closed` while waiting.
- R3: A running slot lasts exactly its delta count of cycles in which `delta_tick` is 1. Cycles with `delta_tick` at 0 do not advance it.
- R4: A thread steps through slots first..last in increasing order and, after the last slot expires, returns to its first slot.
- R5: Only threads whose index is at most `act_m1` (number of active threads minus one) run. The others never affect `gate_closed`.
- R6: A thread i > 0 whose end index equals the end index of thread i-1 never starts.
- R7: Bit `p*8+c` of `gate_closed` is 1 exactly when some running thread's current slot has port bit p set and closed-class bit c set (OR across threads).
- R8: A `stop` pulse clears `running` on the next edge and returns every thread to idle, so all gates are open one cycle later. A later `start` restarts the waits from the beginning.
- R9: `gate_closed` is registered. It shows the thread states one clock edge after they change.
- R10: A slot written with a delta of 0 is held for one delta tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_we | input | 1 | Slot table write strobe |
| slot_waddr | input | 5 | Slot index to write |
| slot_wdelta | input | 19 | Slot hold time in delta ticks |
| slot_wports | input | 5 | Ports the slot applies to, bit p = port p |
| slot_wclosed | input | 8 | Traffic classes whose gates are closed, bit c = class c |
| thr_we | input | 1 | Thread entry write strobe |
| thr_widx | input | 3 | Thread index to write |
| thr_wfirst | input | 5 | First slot of the thread |
| thr_wlast | input | 5 | End (last) slot index of the thread |
| thr_wdelay | input | 32 | Start delay of the thread in time units |
| act_m1 | input | 3 | Number of active threads minus one, sampled at start |
| base_time | input | 32 | Operational start time, sampled at start |
| now | input | 32 | Free-running time value |
| delta_tick | input | 1 | One pulse per delta unit |
| start | input | 1 | Start pulse |
| stop | input | 1 | Stop pulse, takes priority over start |
| running | output | 1 | Schedule engine running |
| gate_closed | output | 40 | Closed-gate flags, bit p*8+c for port p, class c |

## Verification
A thread's state changes on the clock edge where its start condition or its final delta tick is seen, and `gate_closed` reflects that state one edge later. The bench therefore pushes one predicted gate vector per rising edge into a queue and compares the entry from the previous edge with the output sampled at the following falling edge. `running` is checked at the falling edge right after the start or stop pulse's edge. The prediction comes from a separate per-thread model of the wait, hold and wrap rules, run under continuous ticks, under gated ticks, with threads limited by count and by equal end indices, and with a zero-delta slot.

// File: rtl/gcl_pkg.sv
package gcl_pkg;
  localparam int DELTA_W = 19;
  localparam int TC_W    = 8;

  typedef enum logic [1:0] {
    TH_IDLE = 2'd0,
    TH_WAIT = 2'd1,
    TH_RUN  = 2'd2
  } th_state_e;
endpackage

// File: rtl/gcl_slot_table.sv
module gcl_slot_table
  import gcl_pkg::*;
#(
  parameter int SLOTS   = 32,
  parameter int PORTS   = 5,
  parameter int READERS = 8,
  localparam int SA_W   = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [SA_W-1:0]    waddr,
  input  logic [DELTA_W-1:0] wdelta,
  input  logic [PORTS-1:0]   wports,
  input  logic [TC_W-1:0]    wclosed,
  input  logic [SA_W-1:0]    raddr   [READERS],
  output logic [DELTA_W-1:0] rdelta  [READERS],
  output logic [PORTS-1:0]   rports  [READERS],
  output logic [TC_W-1:0]    rclosed [READERS]
);
  logic [DELTA_W-1:0] mem_delta  [SLOTS];
  logic [PORTS-1:0]   mem_ports  [SLOTS];
  logic [TC_W-1:0]    mem_closed [SLOTS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_delta[waddr]  <= wdelta;
      mem_ports[waddr]  <= wports;
      mem_closed[waddr] <= wclosed;
    end
  end

  for (genvar r = 0; r < READERS; r++) begin : g_rd
    assign rdelta[r]  = mem_delta[raddr[r]];
    assign rports[r]  = mem_ports[raddr[r]];
    assign rclosed[r] = mem_closed[raddr[r]];
  end
endmodule

// File: rtl/gcl_thread.sv
module gcl_thread
  import gcl_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int PORTS  = 5,
  parameter int TIME_W = 32,
  localparam int SA_W  = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               en_i,
  input  logic [SA_W-1:0]    first_i,
  input  logic [SA_W-1:0]    last_i,
  input  logic [TIME_W-1:0]  trig_i,
  input  logic [TIME_W-1:0]  now_i,
  input  logic               tick_i,
  output logic [SA_W-1:0]    rd_addr_o,
  input  logic [DELTA_W-1:0] rd_delta_i,
  input  logic [PORTS-1:0]   rd_ports_i,
  input  logic [TC_W-1:0]    rd_closed_i,
  output logic               active_o,
  output logic [PORTS-1:0]   ports_o,
  output logic [TC_W-1:0]    closed_o
);
  th_state_e          state_q;
  logic [SA_W-1:0]    first_q, last_q, idx_q, nxt_idx;
  logic [TIME_W-1:0]  trig_q;
  logic [DELTA_W-1:0] rem_q, load_rem;

  assign nxt_idx   = (idx_q == last_q) ? first_q : idx_q + SA_W'(1);
  assign rd_addr_o = (state_q == TH_RUN) ? nxt_idx : first_q;
  assign load_rem  = (rd_delta_i == '0) ? DELTA_W'(1) : rd_delta_i;
  assign active_o  = (state_q == TH_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= TH_IDLE;
      first_q  <= '0;
      last_q   <= '0;
      idx_q    <= '0;
      trig_q   <= '0;
      rem_q    <= '0;
      ports_o  <= '0;
      closed_o <= '0;
    end else if (stop_i) begin
      state_q <= TH_IDLE;
    end else if (start_i) begin
      state_q <= en_i ? TH_WAIT : TH_IDLE;
      first_q <= first_i;
      last_q  <= last_i;
      trig_q  <= trig_i;
    end else begin
      unique case (state_q)
        TH_WAIT: begin
          if (now_i >= trig_q) begin
            state_q  <= TH_RUN;
            idx_q    <= first_q;
            rem_q    <= load_rem;
            ports_o  <= rd_ports_i;
            closed_o <= rd_closed_i;
          end
        end
        TH_RUN: begin
          if (tick_i) begin
            if (rem_q == DELTA_W'(1)) begin
              idx_q    <= nxt_idx;
              rem_q    <= load_rem;
              ports_o  <= rd_ports_i;
              closed_o <= rd_closed_i;
            end else begin
              rem_q <= rem_q - DELTA_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  a_r4_index_window: assert property (@(posedge clk) disable iff (rst)
    (state_q == TH_RUN && first_q <= last_q) |-> (idx_q >= first_q && idx_q <= last_q));

  a_r3_remain_nonzero: assert property (@(posedge clk) disable iff (rst)
    (state_q == TH_RUN) |-> (rem_q != '0));

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (state_q == TH_RUN && !tick_i && !stop_i && !start_i) |=> ($stable(idx_q) && $stable(rem_q)));

  a_r6_disabled_stays_idle: assert property (@(posedge clk) disable iff (rst)
    (start_i && !stop_i && !en_i) |=> (state_q == TH_IDLE));

  a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (state_q == TH_IDLE));
endmodule

// File: rtl/gcl_gate_merge.sv
module gcl_gate_merge
  import gcl_pkg::*;
#(
  parameter int THREADS = 8,
  parameter int PORTS   = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [THREADS-1:0]    active,
  input  logic [PORTS-1:0]      ports  [THREADS],
  input  logic [TC_W-1:0]       closed [THREADS],
  output logic [PORTS*TC_W-1:0] gate_q
);
  logic [PORTS*TC_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int t = 0; t < THREADS; t++) begin
      for (int p = 0; p < PORTS; p++) begin
        if (active[t] && ports[t][p]) acc[p*TC_W +: TC_W] = acc[p*TC_W +: TC_W] | closed[t];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gate_q <= '0;
    else     gate_q <= acc;
  end

  a_r8_open_when_idle: assert property (@(posedge clk) disable iff (rst)
    (active == '0) |=> (gate_q == '0));

  a_r7_single_thread_passes: assert property (@(posedge clk) disable iff (rst)
    ($onehot(active) && active[0] && ports[0][0]) |=> (gate_q[TC_W-1:0] == $past(closed[0])));
endmodule

// File: rtl/gcl_sequencer.sv
module gcl_sequencer
  import gcl_pkg::*;
#(
  parameter int THREADS = 8,
  parameter int SLOTS   = 32,
  parameter int PORTS   = 5,
  parameter int TIME_W  = 32,
  localparam int SA_W   = $clog2(SLOTS),
  localparam int TH_W   = $clog2(THREADS),
  localparam int GATE_W = PORTS * TC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slot_we,
  input  logic [SA_W-1:0]    slot_waddr,
  input  logic [DELTA_W-1:0] slot_wdelta,
  input  logic [PORTS-1:0]   slot_wports,
  input  logic [TC_W-1:0]    slot_wclosed,
  input  logic               thr_we,
  input  logic [TH_W-1:0]    thr_widx,
  input  logic [SA_W-1:0]    thr_wfirst,
  input  logic [SA_W-1:0]    thr_wlast,
  input  logic [TIME_W-1:0]  thr_wdelay,
  input  logic [TH_W-1:0]    act_m1,
  input  logic [TIME_W-1:0]  base_time,
  input  logic [TIME_W-1:0]  now,
  input  logic               delta_tick,
  input  logic               start,
  input  logic               stop,
  output logic               running,
  output logic [GATE_W-1:0]  gate_closed
);
  logic [SA_W-1:0]    first_tab [THREADS];
  logic [SA_W-1:0]    last_tab  [THREADS];
  logic [TIME_W-1:0]  delay_tab [THREADS];

  logic [SA_W-1:0]    rd_addr   [THREADS];
  logic [DELTA_W-1:0] rd_delta  [THREADS];
  logic [PORTS-1:0]   rd_ports  [THREADS];
  logic [TC_W-1:0]    rd_closed [THREADS];
  logic [PORTS-1:0]   th_ports  [THREADS];
  logic [TC_W-1:0]    th_closed [THREADS];
  logic [THREADS-1:0] th_active;
  logic [THREADS-1:0] th_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < THREADS; i++) begin
        first_tab[i] <= '0;
        last_tab[i]  <= '0;
        delay_tab[i] <= '0;
      end
    end else if (thr_we) begin
      first_tab[thr_widx] <= thr_wfirst;
      last_tab[thr_widx]  <= thr_wlast;
      delay_tab[thr_widx] <= thr_wdelay;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        running <= 1'b0;
    else if (stop)  running <= 1'b0;
    else if (start) running <= 1'b1;
  end

  gcl_slot_table #(.SLOTS(SLOTS), .PORTS(PORTS), .READERS(THREADS)) u_table (
    .clk     (clk),
    .we      (slot_we),
    .waddr   (slot_waddr),
    .wdelta  (slot_wdelta),
    .wports  (slot_wports),
    .wclosed (slot_wclosed),
    .raddr   (rd_addr),
    .rdelta  (rd_delta),
    .rports  (rd_ports),
    .rclosed (rd_closed)
  );

  for (genvar i = 0; i < THREADS; i++) begin : g_thr
    if (i == 0) begin : g_first
      assign th_en[i] = 1'b1;
    end else begin : g_rest
      assign th_en[i] = (TH_W'(i) <= act_m1) && (last_tab[i] != last_tab[i-1]);
    end

    gcl_thread #(.SLOTS(SLOTS), .PORTS(PORTS), .TIME_W(TIME_W)) u_thr (
      .clk         (clk),
      .rst         (rst),
      .start_i     (start),
      .stop_i      (stop),
      .en_i        (th_en[i]),
      .first_i     (first_tab[i]),
      .last_i      (last_tab[i]),
      .trig_i      (base_time + delay_tab[i]),
      .now_i       (now),
      .tick_i      (delta_tick),
      .rd_addr_o   (rd_addr[i]),
      .rd_delta_i  (rd_delta[i]),
      .rd_ports_i  (rd_ports[i]),
      .rd_closed_i (rd_closed[i]),
      .active_o    (th_active[i]),
      .ports_o     (th_ports[i]),
      .closed_o    (th_closed[i])
    );
  end

  gcl_gate_merge #(.THREADS(THREADS), .PORTS(PORTS)) u_merge (
    .clk    (clk),
    .rst    (rst),
    .active (th_active),
    .ports  (th_ports),
    .closed (th_closed),
    .gate_q (gate_closed)
  );

  a_r2_start_sets_running: assert property (@(posedge clk) disable iff (rst)
    (start && !stop) |=> running);

  a_r8_stop_clears_running: assert property (@(posedge clk) disable iff (rst)
    stop |=> !running);

  a_r5_idle_engine_no_threads: assert property (@(posedge clk) disable iff (rst)
    !running |-> (th_active == '0));
endmodule

// File: tb/sim_gcl_sequencer.sv
module sim_gcl_sequencer;
  localparam int TH = 8, SL = 32, PT = 5, TW = 32, TC = 8, DW = 19;
  localparam int SA = $clog2(SL), THW = $clog2(TH), GW = PT * TC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_we = 1'b0, thr_we = 1'b0, start = 1'b0, stop = 1'b0, delta_tick = 1'b1;
  logic [SA-1:0] slot_waddr = '0, thr_wfirst = '0, thr_wlast = '0;
  logic [DW-1:0] slot_wdelta = '0;
  logic [PT-1:0] slot_wports = '0;
  logic [TC-1:0] slot_wclosed = '0;
  logic [THW-1:0] thr_widx = '0, act_m1 = '0;
  logic [TW-1:0] thr_wdelay = '0, base_time = '0, now = '0;
  logic running;
  logic [GW-1:0] gate_closed;

  int checks = 0, fails = 0;
  bit done = 0;
  bit tick_alt = 0;
  string tag = "R1";

  gcl_sequencer #(.THREADS(TH), .SLOTS(SL), .PORTS(PT), .TIME_W(TW)) u0 (.*);

  always #2 clk = ~clk;

  // model copies of the configuration
  int m_delta [SL];
  logic [PT-1:0] m_ports [SL];
  logic [TC-1:0] m_closedv [SL];
  int m_first [TH], m_last [TH];
  logic [TW-1:0] m_delay [TH];
  // model thread state: 0 idle, 1 wait, 2 run
  int s_st [TH], s_idx [TH], s_rem [TH];
  logic [TW-1:0] s_trig [TH];
  logic [PT-1:0] s_ports [TH];
  logic [TC-1:0] s_closed [TH];
  logic [GW-1:0] expq [$];

  initial for (int t = 0; t < TH; t++) begin s_st[t] = 0; s_idx[t] = 0; s_rem[t] = 0; end

  function automatic int hold_of(int d);
    return (d == 0) ? 1 : d;
  endfunction

  // reference model, one step per rising edge
  always @(posedge clk) begin
    logic [GW-1:0] e;
    if (rst || stop) begin
      for (int t = 0; t < TH; t++) s_st[t] = 0;
    end else if (start) begin
      for (int t = 0; t < TH; t++) begin
        bit en;
        en = (t == 0) || ((t <= int'(act_m1)) && (m_last[t] != m_last[t-1]));
        s_st[t] = en ? 1 : 0;
        s_trig[t] = base_time + m_delay[t];
      end
    end else begin
      for (int t = 0; t < TH; t++) begin
        if (s_st[t] == 1 && now >= s_trig[t]) begin
          s_st[t] = 2; s_idx[t] = m_first[t];
          s_rem[t] = hold_of(m_delta[s_idx[t]]);
          s_ports[t] = m_ports[s_idx[t]]; s_closed[t] = m_closedv[s_idx[t]];
        end else if (s_st[t] == 2 && delta_tick) begin
          if (s_rem[t] == 1) begin
            s_idx[t] = (s_idx[t] == m_last[t]) ? m_first[t] : s_idx[t] + 1;
            s_rem[t] = hold_of(m_delta[s_idx[t]]);
            s_ports[t] = m_ports[s_idx[t]]; s_closed[t] = m_closedv[s_idx[t]];
          end else s_rem[t] = s_rem[t] - 1;
        end
      end
    end
    e = '0;
    for (int t = 0; t < TH; t++)
      for (int p = 0; p < PT; p++)
        if (s_st[t] == 2 && s_ports[t][p]) e[p*TC +: TC] = e[p*TC +: TC] | s_closed[t];
    expq.push_back(e);
  end

  // scoreboard monitor: output after edge k+1 matches prediction of edge k
  always @(negedge clk) begin
    if (expq.size() >= 2) begin
      logic [GW-1:0] ex;
      ex = expq.pop_front();
      if (!rst) begin
        checks++;
        if (gate_closed !== ex) begin
          fails++;
          $display("FAIL %s gate_closed actual=%h expected=%h at t=%0t", tag, gate_closed, ex, $time);
        end
      end
    end
  end

  // free-running time and tick pattern, driven away from the active edge
  always @(negedge clk) begin
    now <= now + 1;
    delta_tick <= tick_alt ? now[0] : 1'b1;
  end

  task automatic chk(string t, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic wr_slot(int a, int d, logic [PT-1:0] pm, logic [TC-1:0] cm);
    @(negedge clk);
    slot_we = 1; slot_waddr = SA'(a); slot_wdelta = DW'(d); slot_wports = pm; slot_wclosed = cm;
    m_delta[a] = d; m_ports[a] = pm; m_closedv[a] = cm;
    @(negedge clk);
    slot_we = 0;
  endtask

  task automatic wr_thr(int i, int f, int l, int dl);
    @(negedge clk);
    thr_we = 1; thr_widx = THW'(i); thr_wfirst = SA'(f); thr_wlast = SA'(l); thr_wdelay = TW'(dl);
    m_first[i] = f; m_last[i] = l; m_delay[i] = TW'(dl);
    @(negedge clk);
    thr_we = 0;
  endtask

  task automatic do_start(int am);
    @(negedge clk);
    act_m1 = THW'(am); base_time = now + 5; start = 1;
    @(negedge clk);
    start = 0;
    chk("R2 running after start", 64'(running), 64'd1);
  endtask

  task automatic do_stop();
    @(negedge clk);
    stop = 1;
    @(negedge clk);
    stop = 0;
    chk("R8 running after stop", 64'(running), 64'd0);
  endtask

  task automatic idle_cycles(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    for (int t = 0; t < TH; t++) begin m_first[t] = 0; m_last[t] = 0; m_delay[t] = '0; end
    for (int a = 0; a < SL; a++) begin m_delta[a] = 1; m_ports[a] = '0; m_closedv[a] = '0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    tag = "R1";
    chk("R1 running at reset", 64'(running), 64'd0);
    chk("R1 gates open at reset", 64'(gate_closed), 64'd0);
    for (int a = 0; a < SL; a++) wr_slot(a, 1, '0, '0);
    wr_slot(0, 3, 5'b00001, 8'h01);
    wr_slot(1, 1, 5'b00001, 8'h02);
    wr_slot(2, 2, 5'b00001, 8'h80);
    wr_slot(3, 2, 5'b00011, 8'h10);
    wr_slot(4, 4, 5'b00011, 8'h0C);
    wr_thr(0, 0, 2, 1);
    wr_thr(1, 3, 4, 4);
    wr_thr(2, 0, 4, 2);
    for (int t = 3; t < TH; t++) wr_thr(t, 0, 4, 1);

    tag = "R2/R3/R4/R6/R7/R9 continuous ticks";
    do_start(2);
    idle_cycles(60);

    tag = "R3 gated ticks";
    tick_alt = 1;
    do_start(2);
    idle_cycles(60);
    tick_alt = 0;

    tag = "R8 stop";
    do_stop();
    idle_cycles(3);
    chk("R8 gates open after stop", 64'(gate_closed), 64'd0);

    tag = "R5 one active thread";
    do_start(0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk("R5 port1 untouched", 64'(gate_closed[TC +: TC]), 64'd0);
    end
    do_stop();

    tag = "R10 zero delta slot";
    wr_slot(1, 0, 5'b00001, 8'h02);
    do_start(1);
    idle_cycles(40);
    do_stop();
    idle_cycles(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule